// File: doc/BRIEF.md
# Phase-Interleaved Fine-Step Pulse Width Modulator

This block produces one gate-drive pulse train for a switching power stage. The on-time is set by a duty word in steps of one eighth of the base clock period. A plain counter running on the base clock could only give whole-cycle steps. Here the upper field of the word is matched by a free-running coarse counter on the base clock, and the lower three bits pick one of eight clocks. These clocks share the base frequency and are spaced by 45 degrees. The rising edge of the chosen clock ends the pulse, so the falling edge can land between base clock edges. With the default 13-bit word and a 10 MHz base clock, one word step is 12.5 ns and the switching period is 1024 base cycles.

The eight phase clocks come in on ports. Phase 0 is the base clock, and phase k lags it by k eighths of a period. A new duty word is offered together with a one-cycle load strobe. It is held as pending and takes effect only when the counter wraps, so a running period is never cut short or doubled. A period controller with three states gates the output. After reset the state is WAIT. At each counter wrap it moves to ACTIVE if the word taking effect is nonzero, or to SILENT if it is zero. The named transitions are WAIT→ACTIVE, WAIT→SILENT, ACTIVE→SILENT, SILENT→ACTIVE, and staying in ACTIVE or SILENT at a wrap with the same kind of word. Each fine stop flag is tagged with the period parity. A stop left over from the previous period therefore cannot suppress the start of the next pulse.

Top module: `hrpwm_interleaved`

## Requirements
- R1: For a duty word D with 1 ≤ D ≤ 2^(COARSE_W+FINE_W)−1, the output is high for exactly D eighths of a base clock period in each period. Write D = 8·N + k, where N is the upper COARSE_W bits and k is the lower 3 bits. The fall then comes at the phase-k rising edge during coarse count N when k ≥ 1, and at the base clock edge that starts count N when k = 0.
- R2: The period is 2^COARSE_W base cycles. `period_start` is high for exactly one base cycle, the cycle in which the coarse count is 0. The output rises on the same base clock edge.
- R3: A duty word of zero keeps the output low for the whole period.
- R4: The full-scale word gives a high time one fine step short of the period. The output is then low for exactly one eighth of a base cycle before the next period begins, and the pulse never reaches past the period boundary.
- R5: A word loaded partway through a period does not change that period. It applies from the next counter wrap onward.
- R6: Changes on `duty_word` while `duty_load` is low have no effect on the output.
- R7: Within a period, the output is high for the whole of every base cycle whose coarse count is below N. It is low for the whole of every base cycle whose count is above N.
- R8: The measured high time never decreases as the duty word increases.
- R9: While `rst_n` is low, `pwm_out` and `period_start` are low. After reset, the pending word is zero, so the output stays low until a nonzero word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_phase | input | 2^FINE_W | Phase clocks. Bit 0 is the base clock, and bit k lags it by k/2^FINE_W of a period |
| rst_n | input | 1 | Asynchronous active-low reset for all clock domains |
| duty_word | input | COARSE_W+FINE_W | Requested on-time in fine steps |
| duty_load | input | 1 | Captures `duty_word` as pending on a base clock edge |
| pwm_out | output | 1 | Gate-drive pulse |
| period_start | output | 1 | High during coarse count 0 of each period |

## Verification
A wrong coarse count or latched word shows up within one base cycle as the output level disagreeing with the count-versus-field relation. A stale stop flag from the previous period would hold the output low at the start of the next period. Mid-cycle sampling catches that in the first cycle. A wrong phase selection or an off-by-one in the stop comparison moves the falling edge by whole fine steps. Measuring the high time over a complete period shows this, so a sweep over every word of a small configuration exposes it by the end of the affected period.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    // Period controller states
    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,   // after reset, before first counter wrap
        ST_ACTIVE = 2'd1,   // current period drives a pulse
        ST_SILENT = 2'd2    // current period holds the output low
    } per_state_e;

endpackage

// File: rtl/dpwm_period_ctrl.sv
module dpwm_period_ctrl
    import dpwm_pkg::*;
#(
    parameter int COARSE_W = 10,
    parameter int FINE_W   = 3
) (
    input  logic                         clk_base,
    input  logic                         rst_n,
    input  logic [COARSE_W+FINE_W-1:0]   duty_in,
    input  logic                         duty_load,
    output logic [COARSE_W-1:0]          cnt_o,
    output logic [COARSE_W+FINE_W-1:0]   duty_act_o,
    output logic                         par_o,
    output logic                         base_stop_o,
    output logic                         pulse_on_o,
    output logic                         per_start_o
);
    localparam int DUTY_W = COARSE_W + FINE_W;
    localparam logic [COARSE_W-1:0] CNT_LAST = '1;

    per_state_e state_q, state_d;

    logic [COARSE_W-1:0] cnt_q;
    logic [COARSE_W-1:0] cnt_inc;
    logic [DUTY_W-1:0]   pend_q;
    logic [DUTY_W-1:0]   duty_q;
    logic [DUTY_W-1:0]   duty_take;
    logic [COARSE_W-1:0] coarse_act;
    logic                par_q;
    logic                base_stop_q;
    logic                per_start_q;
    logic                wrap;
    logic                take_on;

    assign wrap       = (cnt_q == CNT_LAST);
    assign cnt_inc    = cnt_q + COARSE_W'(1);
    assign duty_take  = duty_load ? duty_in : pend_q;
    assign take_on    = (duty_take != '0);
    assign coarse_act = duty_q[DUTY_W-1:FINE_W];

    // state register
    always_ff @(posedge clk_base or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions, all taken at the counter wrap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (wrap) begin
                    state_d = take_on ? ST_ACTIVE : ST_SILENT;
                end
            end
            ST_ACTIVE: begin
                if (wrap && !take_on) begin
                    state_d = ST_SILENT;
                end
            end
            ST_SILENT: begin
                if (wrap && take_on) begin
                    state_d = ST_ACTIVE;
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // counter, word latches, parity and base-phase stop
    always_ff @(posedge clk_base or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= CNT_LAST;
            pend_q      <= '0;
            duty_q      <= '0;
            par_q       <= 1'b0;
            base_stop_q <= 1'b0;
            per_start_q <= 1'b0;
        end else begin
            cnt_q       <= cnt_inc;
            per_start_q <= wrap;
            if (duty_load) begin
                pend_q <= duty_in;
            end
            if (wrap) begin
                duty_q      <= duty_take;
                par_q       <= ~par_q;
                base_stop_q <= 1'b0;
            end else begin
                base_stop_q <= (cnt_inc >= coarse_act);
            end
        end
    end

    // outputs
    always_comb begin
        cnt_o       = cnt_q;
        duty_act_o  = duty_q;
        par_o       = par_q;
        base_stop_o = base_stop_q;
        per_start_o = per_start_q;
        pulse_on_o  = (state_q == ST_ACTIVE);
    end

endmodule

// File: rtl/dpwm_phase_stop.sv
module dpwm_phase_stop #(
    parameter int COARSE_W = 10
) (
    input  logic                clk_ph,
    input  logic                rst_n,
    input  logic [COARSE_W-1:0] cnt,
    input  logic [COARSE_W-1:0] stop_at,
    input  logic                par,
    output logic                stop
);
    logic hit_q;
    logic tag_q;

    // Sample the base-domain count on this phase's edge and tag it with the
    // period parity so a hit from the previous period reads as stale.
    always_ff @(posedge clk_ph or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            tag_q <= 1'b0;
        end else begin
            hit_q <= (cnt >= stop_at);
            tag_q <= par;
        end
    end

    assign stop = hit_q & (tag_q == par);

endmodule

// File: rtl/dpwm_edge_mux.sv
module dpwm_edge_mux #(
    parameter int FINE_W = 3
) (
    input  logic                    pulse_on,
    input  logic [(1<<FINE_W)-1:0]  stop_vec,
    input  logic [FINE_W-1:0]       sel,
    output logic                    pwm
);
    always_comb begin
        pwm = pulse_on & ~stop_vec[sel];
    end

endmodule

// File: rtl/hrpwm_interleaved.sv
module hrpwm_interleaved #(
    parameter int COARSE_W = 10,
    parameter int FINE_W   = 3
) (
    input  logic [(1<<FINE_W)-1:0]      clk_phase,
    input  logic                        rst_n,
    input  logic [COARSE_W+FINE_W-1:0]  duty_word,
    input  logic                        duty_load,
    output logic                        pwm_out,
    output logic                        period_start
);
    localparam int NPH    = 1 << FINE_W;
    localparam int DUTY_W = COARSE_W + FINE_W;

    logic [COARSE_W-1:0] cnt_q;
    logic [DUTY_W-1:0]   duty_act;
    logic                par;
    logic                base_stop;
    logic                pulse_on;
    logic [NPH-1:0]      stop_vec;

    dpwm_period_ctrl #(
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W)
    ) u_ctrl (
        .clk_base    (clk_phase[0]),
        .rst_n       (rst_n),
        .duty_in     (duty_word),
        .duty_load   (duty_load),
        .cnt_o       (cnt_q),
        .duty_act_o  (duty_act),
        .par_o       (par),
        .base_stop_o (base_stop),
        .pulse_on_o  (pulse_on),
        .per_start_o (period_start)
    );

    assign stop_vec[0] = base_stop;

    for (genvar k = 1; k < NPH; k++) begin : g_phase
        dpwm_phase_stop #(
            .COARSE_W (COARSE_W)
        ) u_stop (
            .clk_ph  (clk_phase[k]),
            .rst_n   (rst_n),
            .cnt     (cnt_q),
            .stop_at (duty_act[DUTY_W-1:FINE_W]),
            .par     (par),
            .stop    (stop_vec[k])
        );
    end

    dpwm_edge_mux #(
        .FINE_W (FINE_W)
    ) u_mux (
        .pulse_on (pulse_on),
        .stop_vec (stop_vec),
        .sel      (duty_act[FINE_W-1:0]),
        .pwm      (pwm_out)
    );

endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker #(
    parameter int COARSE_W = 10,
    parameter int FINE_W   = 3
) (
    input logic                        clk_base,
    input logic                        rst_n,
    input logic                        pwm_out,
    input logic                        period_start,
    input logic [COARSE_W-1:0]         cnt_q,
    input logic [COARSE_W+FINE_W-1:0]  duty_act
);
    localparam int DUTY_W = COARSE_W + FINE_W;

    logic [COARSE_W-1:0] coarse;
    assign coarse = duty_act[DUTY_W-1:FINE_W];

    assert_single_start_R2: assert property (@(posedge clk_base) disable iff (!rst_n)
        period_start |=> !period_start);

    assert_zero_silent_R3: assert property (@(posedge clk_base) disable iff (!rst_n)
        (period_start && duty_act == '0) |-> !pwm_out);

    assert_word_held_R5: assert property (@(posedge clk_base) disable iff (!rst_n)
        !period_start |-> $stable(duty_act));

    assert_high_below_R7: assert property (@(posedge clk_base) disable iff (!rst_n)
        (duty_act != '0 && cnt_q < coarse) |-> pwm_out);

    assert_low_above_R7: assert property (@(posedge clk_base) disable iff (!rst_n)
        (cnt_q > coarse) |-> !pwm_out);

endmodule

bind hrpwm_interleaved dpwm_checker #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W)
) u_chk (
    .clk_base     (clk_phase[0]),
    .rst_n        (rst_n),
    .pwm_out      (pwm_out),
    .period_start (period_start),
    .cnt_q        (cnt_q),
    .duty_act     (duty_act)
);

// File: tb/test_hrpwm_interleaved.sv
module test_hrpwm_interleaved;
    localparam int CW   = 4;
    localparam int FW   = 3;
    localparam int NPH  = 1 << FW;
    localparam int DW   = CW + FW;
    localparam int DMAX = (1 << DW) - 1;
    localparam int HALF = 10000;          // 50 MHz base clock
    localparam int STEP = 2 * HALF / NPH; // fine step
    localparam int PER  = (1 << CW) * 2 * HALF;

    logic [NPH-1:0] clk_phase;
    logic           rst_n;
    logic [DW-1:0]  duty_word;
    logic           duty_load;
    logic           pwm_out;
    logic           period_start;

    int checks = 0;
    int errors = 0;
    int falls  = 0;
    int last_w = 0;
    longint t_rise = 0;
    longint t_fall = 0;

    for (genvar k = 0; k < NPH; k++) begin : g_clk
        logic ck;
        initial begin
            ck = 1'b0;
            #(k * STEP);
            forever #(HALF) ck = ~ck;
        end
        assign clk_phase[k] = ck;
    end

    hrpwm_interleaved #(.COARSE_W(CW), .FINE_W(FW)) i_hrpwm_interleaved (
        .clk_phase    (clk_phase),
        .rst_n        (rst_n),
        .duty_word    (duty_word),
        .duty_load    (duty_load),
        .pwm_out      (pwm_out),
        .period_start (period_start)
    );

    always @(posedge pwm_out) t_rise = $time;
    always @(negedge pwm_out) begin
        t_fall = $time;
        last_w = int'((t_fall - t_rise) / STEP);
        falls  = falls + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_word(input int d);
        @(negedge clk_phase[0]);
        duty_word = DW'(d);
        duty_load = 1'b1;
        @(negedge clk_phase[0]);
        duty_load = 1'b0;
    endtask

    // Measure the period beginning at the next period start; returns width.
    task automatic measure(input int exp, input string req, output int w);
        int f0;
        @(posedge period_start);
        #1;
        chk(pwm_out == (exp != 0), req, pwm_out, exp != 0);
        f0 = falls;
        @(posedge period_start);
        #1;
        chk((falls - f0) == (exp != 0 ? 1 : 0), req, falls - f0, exp != 0 ? 1 : 0);
        w = (falls - f0 == 0) ? 0 : last_w;
        if (exp != 0) chk(last_w == exp, req, last_w, exp);
    endtask

    initial begin
        #(longint'(60000) * 2 * HALF);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w;
        int prev_w;
        longint t0;
        rst_n     = 1'b0;
        duty_word = '0;
        duty_load = 1'b0;
        repeat (5) @(posedge clk_phase[0]);
        #(HALF / 2);
        chk(pwm_out == 1'b0, "R9", pwm_out, 0);
        chk(period_start == 1'b0, "R9", period_start, 0);
        @(negedge clk_phase[0]);
        rst_n = 1'b1;

        // R9: nothing loaded yet, output stays low
        measure(0, "R9", w);

        // R1 R3 R4 R8: exhaustive sweep of every word
        prev_w = 0;
        for (int d = 0; d <= DMAX; d++) begin
            load_word(d);
            if (d == 0)         measure(d, "R3", w);
            else if (d == DMAX) measure(d, "R4", w);
            else                measure(d, "R1", w);
            if (d == DMAX) begin
                chk((t_rise - t_fall) == STEP, "R4", t_rise - t_fall, STEP);
            end
            chk(w >= prev_w, "R8", w, prev_w);
            prev_w = w;
        end

        // R5: load partway through a running period
        load_word(40);
        measure(40, "R5", w);
        repeat (3) @(negedge clk_phase[0]);
        duty_word = DW'(90);
        duty_load = 1'b1;
        @(negedge clk_phase[0]);
        duty_load = 1'b0;
        @(posedge period_start);
        #1;
        chk(last_w == 40, "R5", last_w, 40);
        @(posedge period_start);
        #1;
        chk(last_w == 90, "R5", last_w, 90);

        // R6: word changes without strobe are ignored
        @(negedge clk_phase[0]);
        duty_word = DW'(17);
        measure(90, "R6", w);
        duty_word = DW'(3);
        measure(90, "R6", w);

        // R2: period length and start flag width
        @(posedge period_start);
        t0 = $time;
        @(negedge period_start);
        chk(($time - t0) == 2 * HALF, "R2", $time - t0, 2 * HALF);
        @(posedge period_start);
        chk(($time - t0) == PER, "R2", $time - t0, PER);

        // R7: level in the middle of each base cycle
        for (int t = 0; t < 3; t++) begin
            int d;
            d = (t == 0) ? 45 : (t == 1) ? 35 : 9;
            load_word(d);
            @(posedge period_start);
            for (int c = 0; c < (1 << CW); c++) begin
                @(negedge clk_phase[0]);
                chk(pwm_out == ((c * NPH + NPH / 2) < d), "R7", pwm_out,
                    (c * NPH + NPH / 2) < d);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule